// File: doc/BRIEF.md
# GPIO Companion Register Block

A 16-bit register block on a simple memory-mapped slave bus. It holds a set of plain storage registers (mode, clock divider, clock control, interrupt request, interrupt mask and interrupt status), a read-only status word, and a power word. Any write to the power word with bit 7 set also sets bits 6 and 15. It also holds the state for 16 general-purpose I/O lines: a direction mask and a level register. A host writes and reads these registers over the bus. Writes take effect on the rising clock edge, and reads are combinational.

Each output line drives the bit of the level register that the direction mask gates. The outputs are registered. They are recomputed only on the clock edge that captures a write to the direction register or to the level register. The 16 input pins are sampled on every clock edge. When a pin has changed since the previous edge, its bit in the level register takes the new value. This update leaves the output lines as they are until the next write to the direction or level register.

Only the low six address bits are decoded, so the map repeats every 64 bytes. Only the low 16 bits of write data are kept.

Top module: `gpio_comp`

## Requirements
- R1: After reset the status word (offset 0x08) reads 0x0002. Every other register reads 0x0000, and `gpioOut` is 0x0000.
- R2: The storage registers at 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C each keep the low 16 bits of `busWrData` when written, and read them back unchanged.
- R3: Only `busAddr[5:0]` selects a register, so an address with any upper bits reaches the same register as its low six bits.
- R4: A write to offset 0x0C stores the low 16 bits of the data. When bit 7 of that data is 1, bits 15 and 6 of the stored value are also 1. For example, 0x0080 reads back as 0x80C0.
- R5: Offset 0x08 always reads 0x0002, and writes to it have no effect.
- R6: A write to offset 0x24 or offset 0x28 stores (data AND direction) into the level register. A read at either offset returns the level register.
- R7: `gpioOut` equals (level AND direction), computed from the values just written. It changes on the clock edge that captures a write to 0x20, 0x24 or 0x28, and never between such writes.
- R8: When a bit of `gpioIn` differs from its value at the previous clock edge, the matching level bit takes the new pin value at that edge. `gpioOut` does not change because of it. Pins are compared against 0 after reset.
- R9: A read of any offset not listed above (including offsets that are not multiples of 4, and 0x2C to 0x3F) returns 0x0000. A write to such an offset changes no register.
- R10: A read changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Byte address; only bits [5:0] are decoded |
| busWe | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data; bits [31:16] are discarded |
| busRdData | output | 16 | Combinational read data for `busAddr` |
| gpioIn | input | 16 | Input pins, sampled on each rising edge |
| gpioOut | output | 16 | Registered output lines, level gated by direction |

## Verification
The bench builds the block with its default parameters: a 12-bit byte address, a 32-bit write bus, 16-bit registers and 16 I/O lines. The wide write bus lets the bench check that the upper data half is discarded. The 12-bit address lets it place writes several 64-byte windows above the base and confirm the aliasing. With 16 lines, each direction and level pattern touches every output bit. The bench can also tell the masking done on level writes apart from the masking that only the outputs apply after a direction write.

// File: rtl/gpio_comp_pkg.sv
package gpio_comp_pkg;
  localparam int DATA_W = 16;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_MODE    = 6'h00;
  localparam logic [OFF_W-1:0] OFF_CLKDIV  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_STATUS  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_POWER   = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_CLKCTL  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_IRQREQ  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IRQMASK = 6'h18;
  localparam logic [OFF_W-1:0] OFF_IRQSTAT = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_DIR     = 6'h20;
  localparam logic [OFF_W-1:0] OFF_LVLW    = 6'h24;
  localparam logic [OFF_W-1:0] OFF_LVLR    = 6'h28;

  localparam logic [DATA_W-1:0] STATUS_VAL = 16'h0002;
  localparam int PWR_TRIG_BIT = 7;
  localparam logic [DATA_W-1:0] PWR_FORCE = 16'h8040;

  typedef enum logic [3:0] {
    RD_NONE, RD_MODE, RD_CLKDIV, RD_STATUS, RD_POWER, RD_CLKCTL,
    RD_IRQREQ, RD_IRQMASK, RD_IRQSTAT, RD_DIR, RD_LEVEL
  } rdSel_e;

  typedef struct packed {
    logic wrMode;
    logic wrClkDiv;
    logic wrPower;
    logic wrClkCtl;
    logic wrIrqReq;
    logic wrIrqMask;
    logic wrIrqStat;
    logic wrDir;
    logic wrLevel;
  } strobes_t;
endpackage

// File: rtl/gpio_comp_ctrl.sv
module gpio_comp_ctrl
  import gpio_comp_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  logic             we,
  output strobes_t         strobes,
  output rdSel_e           rdSel
);
  always_comb begin
    case (offset)
      OFF_MODE:    rdSel = RD_MODE;
      OFF_CLKDIV:  rdSel = RD_CLKDIV;
      OFF_STATUS:  rdSel = RD_STATUS;
      OFF_POWER:   rdSel = RD_POWER;
      OFF_CLKCTL:  rdSel = RD_CLKCTL;
      OFF_IRQREQ:  rdSel = RD_IRQREQ;
      OFF_IRQMASK: rdSel = RD_IRQMASK;
      OFF_IRQSTAT: rdSel = RD_IRQSTAT;
      OFF_DIR:     rdSel = RD_DIR;
      OFF_LVLW,
      OFF_LVLR:    rdSel = RD_LEVEL;
      default:     rdSel = RD_NONE;
    endcase
  end

  // Status is read-only, so it has no write strobe.
  always_comb begin
    strobes = '0;
    if (we) begin
      strobes.wrMode    = (rdSel == RD_MODE);
      strobes.wrClkDiv  = (rdSel == RD_CLKDIV);
      strobes.wrPower   = (rdSel == RD_POWER);
      strobes.wrClkCtl  = (rdSel == RD_CLKCTL);
      strobes.wrIrqReq  = (rdSel == RD_IRQREQ);
      strobes.wrIrqMask = (rdSel == RD_IRQMASK);
      strobes.wrIrqStat = (rdSel == RD_IRQSTAT);
      strobes.wrDir     = (rdSel == RD_DIR);
      strobes.wrLevel   = (rdSel == RD_LEVEL);
    end
  end
endmodule

// File: rtl/gpio_comp_dp.sv
module gpio_comp_dp
  import gpio_comp_pkg::*;
#(
  parameter int GPIO_N = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [GPIO_N-1:0] pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [GPIO_N-1:0] pinOut
);
  logic [DATA_W-1:0] modeReg, clkDivReg, powerReg, clkCtlReg;
  logic [DATA_W-1:0] irqReqReg, irqMaskReg, irqStatReg;
  logic [GPIO_N-1:0] dirReg, levelReg, pinPrev, levelNext, dirNext;
  logic [DATA_W-1:0] powerNext;

  always_comb begin
    powerNext = wrData;
    if (wrData[PWR_TRIG_BIT]) powerNext = wrData | PWR_FORCE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg    <= '0;
      clkDivReg  <= '0;
      powerReg   <= '0;
      clkCtlReg  <= '0;
      irqReqReg  <= '0;
      irqMaskReg <= '0;
      irqStatReg <= '0;
      dirReg     <= '0;
      pinPrev    <= '0;
    end else begin
      if (strobes.wrMode)    modeReg    <= wrData;
      if (strobes.wrClkDiv)  clkDivReg  <= wrData;
      if (strobes.wrPower)   powerReg   <= powerNext;
      if (strobes.wrClkCtl)  clkCtlReg  <= wrData;
      if (strobes.wrIrqReq)  irqReqReg  <= wrData;
      if (strobes.wrIrqMask) irqMaskReg <= wrData;
      if (strobes.wrIrqStat) irqStatReg <= wrData;
      if (strobes.wrDir)     dirReg     <= dirNext;
      pinPrev <= pinIn;
    end
  end

  assign dirNext = strobes.wrDir ? wrData[GPIO_N-1:0] : dirReg;

  for (genvar i = 0; i < GPIO_N; i++) begin : g_line
    // A bus write wins over a pin change in the same cycle.
    always_comb begin
      if (strobes.wrLevel)              levelNext[i] = wrData[i] & dirReg[i];
      else if (pinIn[i] != pinPrev[i])  levelNext[i] = pinIn[i];
      else                              levelNext[i] = levelReg[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        levelReg[i] <= 1'b0;
        pinOut[i]   <= 1'b0;
      end else begin
        levelReg[i] <= levelNext[i];
        if (strobes.wrDir || strobes.wrLevel)
          pinOut[i] <= levelNext[i] & dirNext[i];
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_MODE:    rdData = modeReg;
      RD_CLKDIV:  rdData = clkDivReg;
      RD_STATUS:  rdData = STATUS_VAL;
      RD_POWER:   rdData = powerReg;
      RD_CLKCTL:  rdData = clkCtlReg;
      RD_IRQREQ:  rdData = irqReqReg;
      RD_IRQMASK: rdData = irqMaskReg;
      RD_IRQSTAT: rdData = irqStatReg;
      RD_DIR:     rdData[GPIO_N-1:0] = dirReg;
      RD_LEVEL:   rdData[GPIO_N-1:0] = levelReg;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_comp.sv
module gpio_comp
  import gpio_comp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int GPIO_N = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [GPIO_N-1:0] gpioIn,
  output logic [GPIO_N-1:0] gpioOut
);
  strobes_t strobes;
  rdSel_e   rdSel;

  // Upper address and data bits are intentionally dropped.
  logic unusedHigh;
  assign unusedHigh = ^{busAddr[ADDR_W-1:OFF_W], busWrData[BUS_W-1:DATA_W]};

  gpio_comp_ctrl u_ctrl (
    .offset (busAddr[OFF_W-1:0]),
    .we     (busWe),
    .strobes(strobes),
    .rdSel  (rdSel)
  );

  gpio_comp_dp #(.GPIO_N(GPIO_N)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .rdSel  (rdSel),
    .wrData (busWrData[DATA_W-1:0]),
    .pinIn  (gpioIn),
    .rdData (busRdData),
    .pinOut (gpioOut)
  );
endmodule

// File: rtl/gpio_comp_checker.sv
module gpio_comp_checker
  import gpio_comp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int GPIO_N = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [BUS_W-1:0]  busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [GPIO_N-1:0] gpioOut
);
  logic [OFF_W-1:0] off;
  logic gpioWr, lvlWr, known;
  logic [GPIO_N-1:0] dirShadow;
  logic pwrTrig;

  assign off    = busAddr[OFF_W-1:0];
  assign lvlWr  = busWe && (off == OFF_LVLW || off == OFF_LVLR);
  assign gpioWr = lvlWr || (busWe && off == OFF_DIR);
  assign known  = (off[1:0] == 2'b00) && (off <= OFF_LVLR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirShadow <= '0;
      pwrTrig   <= 1'b0;
    end else begin
      if (busWe && off == OFF_DIR) dirShadow <= busWrData[GPIO_N-1:0];
      if (busWe && off == OFF_POWER) pwrTrig <= busWrData[PWR_TRIG_BIT];
    end
  end

  p_power_force_r4: assert property (@(posedge clk) disable iff (!rstN)
    (off == OFF_POWER && pwrTrig) |-> (busRdData[15] && busRdData[6]));

  p_status_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (off == OFF_STATUS) |-> (busRdData == STATUS_VAL));

  p_level_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    lvlWr |=> (gpioOut == ($past(busWrData[GPIO_N-1:0]) & dirShadow)));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !gpioWr |=> $stable(gpioOut));

  p_undecoded_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !known |-> (busRdData == '0));
endmodule

bind gpio_comp gpio_comp_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .GPIO_N(GPIO_N)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .gpioOut  (gpioOut)
);

// File: tb/gpio_comp_bench.sv
module gpio_comp_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [15:0] gpioIn = '0;
  logic [15:0] gpioOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_comp u_gpio_comp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWrData(busWrData), .busRdData(busRdData),
    .gpioIn(gpioIn), .gpioOut(gpioOut)
  );

  // {we, addr, data, expected read}
  localparam logic [60:0] TBL [0:15] = '{
    {1'b1, 12'h000, 32'hAAAA5A5A, 16'h0000},
    {1'b1, 12'h004, 32'h00001234, 16'h0000},
    {1'b1, 12'h010, 32'h0000BEEF, 16'h0000},
    {1'b1, 12'h014, 32'h00000F0F, 16'h0000},
    {1'b1, 12'h018, 32'h0000F0F0, 16'h0000},
    {1'b1, 12'h01C, 32'h00007777, 16'h0000},
    {1'b0, 12'h000, 32'h00000000, 16'h5A5A},
    {1'b0, 12'h004, 32'h00000000, 16'h1234},
    {1'b0, 12'h010, 32'h00000000, 16'hBEEF},
    {1'b0, 12'h014, 32'h00000000, 16'h0F0F},
    {1'b0, 12'h018, 32'h00000000, 16'hF0F0},
    {1'b0, 12'h01C, 32'h00000000, 16'h7777},
    {1'b1, 12'h000, 32'hFFFF0000, 16'h0000},
    {1'b0, 12'h000, 32'h00000000, 16'h0000},
    {1'b1, 12'h01C, 32'hFFFF0001, 16'h0000},
    {1'b0, 12'h01C, 32'h00000000, 16'h0001}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1 d = busRdData;
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] outBefore;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 'h28; a += 4) begin
      rd(a[11:0], v);
      check("R1 reset read", v, (a == 'h08) ? 16'h0002 : 16'h0000);
    end
    check("R1 reset gpioOut", gpioOut, 16'h0000);

    // R2 vector table
    for (int i = 0; i < 16; i++) begin
      if (TBL[i][60]) wr(TBL[i][59:48], TBL[i][47:16]);
      else begin
        rd(TBL[i][59:48], v);
        check($sformatf("R2 table entry %0d", i), v, TBL[i][15:0]);
      end
    end

    // R3 aliasing through upper address bits
    wr(12'h044, 32'h00005555);
    rd(12'h004, v);  check("R3 alias write", v, 16'h5555);
    rd(12'h844, v);  check("R3 alias read", v, 16'h5555);

    // R4 power auto-set
    wr(12'h00C, 32'h00000080);
    rd(12'h00C, v);  check("R4 trigger set", v, 16'h80C0);
    wr(12'h00C, 32'h00000F7F);
    rd(12'h00C, v);  check("R4 trigger clear", v, 16'h0F7F);
    wr(12'h00C, 32'h00000001);
    rd(12'h00C, v);  check("R4 plain value", v, 16'h0001);

    // R5 status read-only
    wr(12'h008, 32'h0000FFFF);
    rd(12'h008, v);  check("R5 status after write", v, 16'h0002);

    // R7 direction write timing
    wr(12'h024, 32'h0000FFFF);  // dir is 0 -> level 0
    rd(12'h028, v);  check("R6 level masked by zero dir", v, 16'h0000);
    @(negedge clk);
    busAddr = 12'h020; busWrData = 32'h000000FF; busWe = 1'b1;
    #1 check("R7 out before edge", gpioOut, 16'h0000);
    @(negedge clk); busWe = 1'b0;
    check("R7 out after dir write", gpioOut, 16'h0000);

    // R6 level write masking and alias offsets
    wr(12'h024, 32'hFFFFABCD);
    rd(12'h024, v);  check("R6 level at write offset", v, 16'h00CD);
    rd(12'h028, v);  check("R6 level at read offset", v, 16'h00CD);
    check("R7 out follows level", gpioOut, 16'h00CD);
    wr(12'h028, 32'h00001234);
    rd(12'h024, v);  check("R6 write via read offset", v, 16'h0034);
    check("R7 out after alias write", gpioOut, 16'h0034);

    // R8 pin changes update level, not outputs
    wr(12'h024, 32'h000000F0);
    check("R7 out set F0", gpioOut, 16'h00F0);
    @(negedge clk); gpioIn = 16'h0F00;
    @(negedge clk);
    rd(12'h028, v);  check("R8 level follows pins", v, 16'h0FF0);
    check("R8 out unchanged by pins", gpioOut, 16'h00F0);
    @(negedge clk); gpioIn = 16'h0E00;
    @(negedge clk);
    rd(12'h028, v);  check("R8 pin falls", v, 16'h0EF0);
    wr(12'h020, 32'h00000FFF);
    check("R7 out after dir widen", gpioOut, 16'h0EF0);
    rd(12'h028, v);  check("R7 dir write keeps level", v, 16'h0EF0);

    // R9 undecoded offsets
    wr(12'h02C, 32'h0000FFFF);
    wr(12'h001, 32'h0000FFFF);
    wr(12'h03C, 32'h0000FFFF);
    rd(12'h02C, v);  check("R9 read 2C", v, 16'h0000);
    rd(12'h002, v);  check("R9 read 02", v, 16'h0000);
    rd(12'h000, v);  check("R9 mode untouched", v, 16'h0000);
    rd(12'h004, v);  check("R9 clkdiv untouched", v, 16'h5555);
    rd(12'h020, v);  check("R9 dir untouched", v, 16'h0FFF);
    check("R9 out untouched", gpioOut, 16'h0EF0);

    // R10 reads have no side effects
    outBefore = gpioOut;
    rd(12'h028, v);
    rd(12'h028, v);  check("R10 repeated read", v, 16'h0EF0);
    rd(12'h00C, v);  check("R10 power stable", v, 16'h0001);
    check("R10 out stable", gpioOut, outBefore);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule